// File: doc/BRIEF.md
# DMA Address Translation Unit

This block stands between DMA devices and physical memory. Each DMA request carries a device address, a selector saying how many address bits the issuing device actually drives, a write flag and a transfer length. The block looks the page up in an internal table of page descriptors and returns a physical address, together with a cache-inhibit indication and a fault code. The input space is 24 bits wide and cut into 8 KB pages. The output is 32 bits wide. The table holds one 32-bit descriptor per input page.

A device with a narrow address bus is placed at the top of the input space. The block sets every address bit at or above the device's width to one before the lookup. Each descriptor can mark its page as write-protected. It can also demand that transfers to the page come in whole 16-byte blocks. Its two-bit type field says whether the page is valid, unused or malformed. A successful access sets the page's used flag, and a write also sets its modified flag. A CPU-side port reads and writes whole descriptors by table index.

Top module: `dma_xlate_unit`

## Requirements
- R1: After reset every descriptor reads as zero (type 00, invalid), resp_valid is 0 and cpu_rdata is 0.
- R2: A request that does not fault returns resp_fault 0 and a resp_paddr made of descriptor bits [31:13] above the extended request address bits [12:0]. resp_ci equals descriptor bit 6.
- R3: Before the lookup, every request address bit whose position is greater than or equal to req_aw is forced to 1. If req_aw is 24 or more, the address is used unchanged. The page index is extended address bits [23:13].
- R4: A descriptor whose type bits [1:0] are 00 gives fault code 1 (invalid page).
- R5: A descriptor whose type bit 1 is set gives fault code 2 (malformed). This takes precedence over every other fault, and such a descriptor never translates.
- R6: A write to a valid page whose write-protect bit (bit 2) is set gives fault code 3. A read of that page translates normally. This check comes before the block check.
- R7: For a valid page whose full-block bit (bit 5) is set, a request whose req_len is not a multiple of 16 gives fault code 4. A multiple of 16 is accepted.
- R8: A faulted response has resp_paddr 0 and resp_ci 0, and it leaves the descriptor unchanged.
- R9: A successful read sets the descriptor's used bit (bit 3). A successful write sets both the used bit and the modified bit (bit 4). The update is visible from the cycle after acceptance.
- R10: req_ready is high whenever no response is held or resp_ready is high. An accepted request produces resp_valid on the next cycle. A held response keeps its values while resp_ready is low.
- R11: With cpu_we high, cpu_wdata is written to entry cpu_idx. cpu_rdata shows, one cycle later, the entry that was indexed by cpu_idx.
- R12: A CPU write to the entry being looked up in the same cycle wins over the used/modified update. That lookup translates with the old descriptor, and the next request sees the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | DMA request present |
| req_ready | output | 1 | Request can be accepted |
| req_addr | input | IN_AW | DMA device address |
| req_aw | input | AW_SEL_W | Number of address bits the device drives |
| req_wr | input | 1 | Request is a write |
| req_len | input | LEN_W | Transfer length in bytes |
| resp_valid | output | 1 | Response present |
| resp_ready | input | 1 | Response taken |
| resp_paddr | output | OUT_AW | Physical address, zero on fault |
| resp_ci | output | 1 | Cache inhibit for the access |
| resp_fault | output | 3 | 0 none, 1 invalid, 2 malformed, 3 protect, 4 block size |
| cpu_we | input | 1 | Descriptor write strobe |
| cpu_idx | input | IDX_W | Descriptor index |
| cpu_wdata | input | OUT_AW | Descriptor write data |
| cpu_rdata | output | OUT_AW | Descriptor read data, one cycle after the index |

## Verification
The bench builds the unit with an 11-bit input space, 128-byte pages and an 8-bit length. This leaves a 16-entry table. Every entry can then be loaded with a distinct descriptor and read back. Every entry is also hit with reads and writes at aligned and misaligned lengths, so each fault code and each flag update is reached. Every address-width selector from 0 up to past the full width is swept. The bench also covers a held response, and a CPU write that collides with a lookup of the same entry.

// File: rtl/dxu_pkg.sv
package dxu_pkg;
    typedef enum logic [2:0] {
        FLT_NONE      = 3'd0,
        FLT_INVALID   = 3'd1,
        FLT_MALFORMED = 3'd2,
        FLT_PROTECT   = 3'd3,
        FLT_BLOCK     = 3'd4
    } fault_e;

    localparam int unsigned BIT_CI   = 6;
    localparam int unsigned BIT_BX   = 5;
    localparam int unsigned BIT_MOD  = 4;
    localparam int unsigned BIT_USED = 3;
    localparam int unsigned BIT_WP   = 2;
    localparam int unsigned BLOCK_LOG2 = 4;
endpackage

// File: rtl/dxu_addr_extend.sv
module dxu_addr_extend #(
    parameter int IN_AW    = 24,
    parameter int AW_SEL_W = 5
) (
    input  logic [IN_AW-1:0]    addr,
    input  logic [AW_SEL_W-1:0] dev_aw,
    output logic [IN_AW-1:0]    ext_addr
);
    for (genvar i = 0; i < IN_AW; i++) begin : g_bit
        assign ext_addr[i] = (32'(dev_aw) <= i) ? 1'b1 : addr[i];
    end
endmodule

// File: rtl/dxu_desc_check.sv
module dxu_desc_check
    import dxu_pkg::*;
#(
    parameter int DW    = 32,
    parameter int LEN_W = 16
) (
    input  logic [DW-1:0]    desc,
    input  logic             wr,
    input  logic [LEN_W-1:0] len,
    output fault_e           fault
);
    logic len_odd;
    assign len_odd = |len[BLOCK_LOG2-1:0];

    always_comb begin
        if (desc[1]) begin
            fault = FLT_MALFORMED;
        end else if (!desc[0]) begin
            fault = FLT_INVALID;
        end else if (wr && desc[BIT_WP]) begin
            fault = FLT_PROTECT;
        end else if (desc[BIT_BX] && len_odd) begin
            fault = FLT_BLOCK;
        end else begin
            fault = FLT_NONE;
        end
    end
endmodule

// File: rtl/dxu_table.sv
module dxu_table
    import dxu_pkg::*;
#(
    parameter int ENTRIES = 2048,
    parameter int DW      = 32,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_we,
    input  logic [IDX_W-1:0] cpu_idx,
    input  logic [DW-1:0]    cpu_wdata,
    input  logic             upd_en,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic             upd_mod,
    input  logic [IDX_W-1:0] lk_idx,
    output logic [DW-1:0]    lk_desc,
    output logic [DW-1:0]    rd_desc
);
    logic [DW-1:0] mem_q [ENTRIES];
    logic [DW-1:0] mem_d [ENTRIES];

    assign lk_desc = mem_q[lk_idx];
    assign rd_desc = mem_q[cpu_idx];

    always_comb begin
        mem_d = mem_q;
        if (upd_en && !(cpu_we && (cpu_idx == upd_idx))) begin
            mem_d[upd_idx][BIT_USED] = 1'b1;
            if (upd_mod) begin
                mem_d[upd_idx][BIT_MOD] = 1'b1;
            end
        end
        if (cpu_we) begin
            mem_d[cpu_idx] = cpu_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_q <= '{default: '0};
        end else begin
            mem_q <= mem_d;
        end
    end
endmodule

// File: rtl/dma_xlate_unit.sv
module dma_xlate_unit
    import dxu_pkg::*;
#(
    parameter int IN_AW     = 24,
    parameter int PAGE_BITS = 13,
    parameter int OUT_AW    = 32,
    parameter int LEN_W     = 16,
    parameter int AW_SEL_W  = $clog2(IN_AW + 1),
    parameter int IDX_W     = IN_AW - PAGE_BITS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [IN_AW-1:0]    req_addr,
    input  logic [AW_SEL_W-1:0] req_aw,
    input  logic                req_wr,
    input  logic [LEN_W-1:0]    req_len,
    output logic                resp_valid,
    input  logic                resp_ready,
    output logic [OUT_AW-1:0]   resp_paddr,
    output logic                resp_ci,
    output logic [2:0]          resp_fault,
    input  logic                cpu_we,
    input  logic [IDX_W-1:0]    cpu_idx,
    input  logic [OUT_AW-1:0]   cpu_wdata,
    output logic [OUT_AW-1:0]   cpu_rdata
);
    localparam int ENTRIES = 1 << IDX_W;

    typedef struct packed {
        logic              rv;
        logic [OUT_AW-1:0] paddr;
        logic              ci;
        fault_e            fault;
        logic [OUT_AW-1:0] rdata;
    } state_t;

    state_t st_d, st_q;

    logic [IN_AW-1:0]  ext_addr;
    logic [IDX_W-1:0]  lk_idx;
    logic [OUT_AW-1:0] lk_desc;
    logic [OUT_AW-1:0] rd_desc;
    fault_e            lk_fault;
    logic              accept;
    logic              upd_en;

    dxu_addr_extend #(.IN_AW(IN_AW), .AW_SEL_W(AW_SEL_W)) i_ext (
        .addr     (req_addr),
        .dev_aw   (req_aw),
        .ext_addr (ext_addr)
    );

    assign lk_idx = ext_addr[IN_AW-1:PAGE_BITS];

    dxu_table #(.ENTRIES(ENTRIES), .DW(OUT_AW)) i_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_we    (cpu_we),
        .cpu_idx   (cpu_idx),
        .cpu_wdata (cpu_wdata),
        .upd_en    (upd_en),
        .upd_idx   (lk_idx),
        .upd_mod   (req_wr),
        .lk_idx    (lk_idx),
        .lk_desc   (lk_desc),
        .rd_desc   (rd_desc)
    );

    dxu_desc_check #(.DW(OUT_AW), .LEN_W(LEN_W)) i_chk (
        .desc  (lk_desc),
        .wr    (req_wr),
        .len   (req_len),
        .fault (lk_fault)
    );

    assign req_ready = !st_q.rv || resp_ready;
    assign accept    = req_valid && req_ready;
    assign upd_en    = accept && (lk_fault == FLT_NONE);

    always_comb begin
        st_d = st_q;
        st_d.rdata = rd_desc;
        if (resp_ready) begin
            st_d.rv = 1'b0;
        end
        if (accept) begin
            st_d.rv    = 1'b1;
            st_d.fault = lk_fault;
            if (lk_fault == FLT_NONE) begin
                st_d.paddr = {lk_desc[OUT_AW-1:PAGE_BITS], ext_addr[PAGE_BITS-1:0]};
                st_d.ci    = lk_desc[BIT_CI];
            end else begin
                st_d.paddr = '0;
                st_d.ci    = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{rv: 1'b0, paddr: '0, ci: 1'b0, fault: FLT_NONE, rdata: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign resp_valid = st_q.rv;
    assign resp_paddr = st_q.paddr;
    assign resp_ci    = st_q.ci;
    assign resp_fault = st_q.fault;
    assign cpu_rdata  = st_q.rdata;
endmodule

// File: rtl/dxu_checker.sv
module dxu_checker #(
    parameter int IN_AW     = 24,
    parameter int PAGE_BITS = 13,
    parameter int OUT_AW    = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [IN_AW-1:0]  ext_addr,
    input logic              req_wr,
    input logic              resp_valid,
    input logic              resp_ready,
    input logic [OUT_AW-1:0] resp_paddr,
    input logic              resp_ci,
    input logic [2:0]        resp_fault,
    input logic [OUT_AW-1:0] lk_desc
);
    logic acc;
    assign acc = req_valid && req_ready;

    // R10
    resp_follows_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> resp_valid);

    // R10
    resp_held_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_ready) |=> (resp_valid && $stable(resp_paddr)
                                         && $stable(resp_fault) && $stable(resp_ci)));

    // R8
    fault_zero_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_fault != 3'd0) |-> (resp_paddr == '0 && !resp_ci));

    // R5
    malformed_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && lk_desc[1]) |=> (resp_fault == 3'd2));

    // R6
    protect_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && lk_desc[1:0] == 2'b01 && lk_desc[2] && req_wr) |=> (resp_fault == 3'd3));

    // R2
    offset_passthrough_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> (resp_fault != 3'd0 ||
                 resp_paddr[PAGE_BITS-1:0] == $past(ext_addr[PAGE_BITS-1:0])));
endmodule

bind dma_xlate_unit dxu_checker #(
    .IN_AW(IN_AW), .PAGE_BITS(PAGE_BITS), .OUT_AW(OUT_AW)
) i_dxu_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .ext_addr   (ext_addr),
    .req_wr     (req_wr),
    .resp_valid (resp_valid),
    .resp_ready (resp_ready),
    .resp_paddr (resp_paddr),
    .resp_ci    (resp_ci),
    .resp_fault (resp_fault),
    .lk_desc    (lk_desc)
);

// File: tb/test_dma_xlate_unit.sv
`timescale 1ns/1ps
module test_dma_xlate_unit;
    localparam int IN_AW = 11, PB = 7, OUT_AW = 32, LEN_W = 8;
    localparam int AWS = $clog2(IN_AW + 1);
    localparam int IW = IN_AW - PB;
    localparam int NE = 1 << IW;

    logic clk = 0, rst_n = 0;
    logic req_valid = 0, req_wr = 0, resp_ready = 1, cpu_we = 0;
    logic [IN_AW-1:0] req_addr = '0;
    logic [AWS-1:0] req_aw = '0;
    logic [LEN_W-1:0] req_len = '0;
    logic [IW-1:0] cpu_idx = '0;
    logic [OUT_AW-1:0] cpu_wdata = '0;
    logic req_ready, resp_valid, resp_ci;
    logic [OUT_AW-1:0] resp_paddr, cpu_rdata;
    logic [2:0] resp_fault;

    int checks = 0, errors = 0, cycles = 0;
    logic [OUT_AW-1:0] model [NE];

    always #4 clk = ~clk;

    dma_xlate_unit #(.IN_AW(IN_AW), .PAGE_BITS(PB), .OUT_AW(OUT_AW), .LEN_W(LEN_W)) i_dma_xlate_unit (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_aw(req_aw), .req_wr(req_wr), .req_len(req_len),
        .resp_valid(resp_valid), .resp_ready(resp_ready), .resp_paddr(resp_paddr),
        .resp_ci(resp_ci), .resp_fault(resp_fault), .cpu_we(cpu_we), .cpu_idx(cpu_idx),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata));

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [OUT_AW-1:0] gen_desc(input int e);
        logic [OUT_AW-1:0] d;
        d = (32'(e) * 32'h9E3779B1 + 32'h1234_5000) & ~32'(7'h7F);
        if (e % 6 == 0) d[1:0] = 2'b00;
        else if (e % 6 == 3) d[1:0] = (e % 12 == 3) ? 2'b11 : 2'b10;
        else d[1:0] = 2'b01;
        d[2] = e[0] ^ e[3];
        d[5] = e[2];
        d[6] = e[1];
        return d;
    endfunction

    task automatic cpu_write(input int idx, input logic [OUT_AW-1:0] d);
        @(negedge clk);
        cpu_we = 1; cpu_idx = IW'(idx); cpu_wdata = d;
        @(negedge clk);
        cpu_we = 0;
        model[idx] = d;
    endtask

    task automatic cpu_read_chk(input int idx, input string tag);
        @(negedge clk);
        cpu_idx = IW'(idx);
        @(negedge clk);
        chk(tag, 64'(cpu_rdata), 64'(model[idx]));
    endtask

    // expected result from the requirements: {fault, ci, paddr}
    task automatic expect_req(input logic [IN_AW-1:0] a, input int aw, input logic wr,
                              input logic [LEN_W-1:0] len, output logic [35:0] res);
        logic [IN_AW-1:0] ea;
        logic [OUT_AW-1:0] d;
        int idx;
        logic [2:0] f;
        for (int i = 0; i < IN_AW; i++) ea[i] = (i >= aw) ? 1'b1 : a[i];   // R3
        idx = int'(ea[IN_AW-1:PB]);
        d = model[idx];
        if (d[1]) f = 3'd2;                         // R5
        else if (!d[0]) f = 3'd1;                   // R4
        else if (wr && d[2]) f = 3'd3;              // R6
        else if (d[5] && (len[3:0] != 0)) f = 3'd4; // R7
        else f = 3'd0;
        if (f == 0) begin
            res = {f, d[6], d[OUT_AW-1:PB], ea[PB-1:0]};            // R2
            model[idx][3] = 1'b1;                                  // R9
            if (wr) model[idx][4] = 1'b1;
        end else begin
            res = {f, 1'b0, 32'h0};                                 // R8
        end
    endtask

    task automatic do_req(input logic [IN_AW-1:0] a, input int aw, input logic wr,
                          input logic [LEN_W-1:0] len, input string tag);
        logic [35:0] exp;
        @(negedge clk);
        req_valid = 1; req_addr = a; req_aw = AWS'(aw); req_wr = wr; req_len = len;
        expect_req(a, aw, wr, len, exp);
        @(negedge clk);
        req_valid = 0;
        chk({tag, " valid"}, 64'(resp_valid), 64'd1);
        chk(tag, 64'({resp_fault, resp_ci, resp_paddr}), 64'(exp));
    endtask

    initial begin
        cycles = 0;
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                checks++; errors++;
                $display("FAIL watchdog expired");
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        logic [35:0] e1;
        logic [OUT_AW-1:0] d_old, d_new;
        logic [LEN_W-1:0] lens [3];
        lens[0] = 8'd16; lens[1] = 8'd24; lens[2] = 8'd48;
        for (int i = 0; i < NE; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 resp_valid", 64'(resp_valid), 64'd0);
        chk("R1 rdata", 64'(cpu_rdata), 64'd0);
        rst_n = 1;
        for (int i = 0; i < NE; i++) cpu_read_chk(i, "R1 entry after reset");
        chk("R10 ready idle", 64'(req_ready), 64'd1);

        // R11 load and read back every entry
        for (int i = 0; i < NE; i++) cpu_write(i, gen_desc(i));
        for (int i = 0; i < NE; i++) cpu_read_chk(i, "R11 readback");

        // R2 R4 R5 R6 R7 R8 sweep over entries, direction and length
        for (int e = 0; e < NE; e++)
            for (int w = 0; w < 2; w++)
                for (int l = 0; l < 3; l++)
                    do_req({IW'(e), PB'(e * 13 + l * 29)}, IN_AW, w[0], lens[l],
                           "R2 sweep");
        // R9 flags after the sweep
        for (int i = 0; i < NE; i++) cpu_read_chk(i, "R9 flag update");

        // R3 width selector sweep
        for (int aw = 0; aw <= 12; aw++)
            do_req(11'h0A5 ^ IN_AW'(aw * 37), aw, 1'b0, 8'd32, "R3 width extend");

        // R10 held response and back-pressure
        d_old = 32'hCAFE_0000 | 32'h41;
        cpu_write(1, d_old);
        @(negedge clk);
        resp_ready = 0; req_valid = 1; req_addr = {IW'(1), PB'(5)}; req_aw = AWS'(IN_AW);
        req_wr = 0; req_len = 8'd16;
        expect_req(req_addr, IN_AW, 1'b0, 8'd16, e1);
        @(negedge clk);
        req_addr = {IW'(1), PB'(9)};
        chk("R10 ready low while held", 64'(req_ready), 64'd0);
        @(negedge clk);
        chk("R10 held response", 64'({resp_valid, resp_fault, resp_ci, resp_paddr}),
            64'({1'b1, e1}));
        resp_ready = 1;
        expect_req(req_addr, IN_AW, 1'b0, 8'd16, e1);
        @(negedge clk);
        req_valid = 0;
        chk("R10 second after release", 64'({resp_valid, resp_fault, resp_ci, resp_paddr}),
            64'({1'b1, e1}));
        @(negedge clk);
        chk("R10 valid drops", 64'(resp_valid), 64'd0);

        // R12 CPU write collides with lookup of the same entry
        d_old = 32'h1357_8000 | 32'h01;
        d_new = 32'h2468_0000 | 32'h41;
        cpu_write(2, d_old);
        @(negedge clk);
        cpu_we = 1; cpu_idx = IW'(2); cpu_wdata = d_new;
        req_valid = 1; req_addr = {IW'(2), PB'(3)}; req_aw = AWS'(IN_AW); req_wr = 1;
        req_len = 8'd16;
        @(negedge clk);
        cpu_we = 0; req_valid = 0;
        chk("R12 lookup uses old", 64'({resp_fault, resp_ci, resp_paddr}),
            64'({3'd0, 1'b0, d_old[31:PB], 7'd3}));
        model[2] = d_new;
        cpu_read_chk(2, "R12 cpu write wins");
        do_req({IW'(2), PB'(100)}, IN_AW, 1'b1, 8'd32, "R12 next sees new");
        cpu_read_chk(2, "R9 used and modified");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule